// File: doc/BRIEF.md
# Banked Gamma Correction Table

This block corrects the red, green and blue components of a pixel stream through a programmable table. Each component carries a 10-bit code that addresses one of 1024 table entries held per colour. The entry read out becomes the corrected component. The output is 12 bits wide. Software fills the table through a simple word write port. A bank register chooses which quarter of the table, 256 entries, the write windows reach. The same register also chooses the data width and whether delta decoding is on.

Two layouts of the table words are supported. In the narrow layout, one word carries all three 10-bit components of an entry. In the wide layout, each component is 12 bits: red and green share one window, and blue comes from a second window. With delta decoding on, each odd entry stores the step from the even entry just below it. The block rebuilds the absolute value during the lookup. The pixel path is a two-stage pipeline with a valid flag.

Top module: `gamma_lut_pipe`

## Requirements
- R1: After reset, bank 0 is selected, the narrow 10-bit layout is active, delta decoding is off and out_valid is 0.
- R2: A write to byte address 0x100 loads the bank register. Bits 1:0 give the bank, bit 2 set selects the wide 12-bit layout and bit 3 set enables delta decoding.
- R3: In the narrow layout, a write to 0x700 + 4*i updates entry bank*256+i. Red comes from data bits 29:20, green from bits 19:10 and blue from bits 9:0.
- R4: In the wide layout, a write to 0x700 + 4*i sets red from bits 11:0 and green from bits 23:12 of entry bank*256+i. The blue entry is left as it was. A write to 0xB00 + 4*i sets blue from bits 11:0.
- R5: In the narrow layout, a write to the 0xB00 window changes no entry.
- R6: Each pixel component selects the entry with its own 10-bit code. In the narrow layout the output is the low 10 bits of that entry, with bits 11:10 at zero. In the wide layout the output is the full 12 bits.
- R7: With delta decoding on, an even code returns its entry unchanged. An odd code returns the sum of its entry and the entry one below, wrapped to the active width (10 or 12 bits).
- R8: With delta decoding off, odd entries are returned as absolute values.
- R9: out_valid is high exactly two clock edges after each edge on which in_valid was high, and low otherwise.
- R10: A lookup uses the table and bank register contents from before its own sampling edge. A table or register write on that same edge first affects the following pixel.
- R11: Writes to any other address, including misaligned ones (address bits 1:0 not zero), change neither the table nor the bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 10 | Red code |
| in_g | input | 10 | Green code |
| in_b | input | 10 | Blue code |
| out_valid | output | 1 | Corrected pixel valid |
| out_r | output | 12 | Corrected red |
| out_g | output | 12 | Corrected green |
| out_b | output | 12 | Corrected blue |

## Verification
A pixel sampled on one edge produces its corrected components and out_valid after the second edge that follows. Table and bank register writes act on the edge they are sampled, so any pixel sampled later sees them. The bench drives all inputs on the falling edge and computes each pixel's expected output from its own model table at that moment, before it applies that cycle's write to the model. It holds the expected result for two falling edges and compares out_valid and all three components on every falling edge, so each idle cycle is checked as well.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

    localparam int IDX_W    = 10;
    localparam int BANK_W   = 2;
    localparam int ENT_W    = IDX_W - BANK_W;
    localparam int DW       = 12;
    localparam int NARROW_W = 10;
    localparam int ADDR_W   = 12;
    localparam int WORD_W   = 32;
    localparam int NCH      = 3;
    localparam int ENTRIES  = 1 << IDX_W;
    localparam int WIN_SPAN = (1 << ENT_W) * 4;

    localparam logic [ADDR_W-1:0] CFG_ADDR  = 12'h100;
    localparam logic [ADDR_W-1:0] WIN0_BASE = 12'h700;
    localparam logic [ADDR_W-1:0] WIN1_BASE = 12'hB00;

    localparam int WIDE_BIT  = BANK_W;
    localparam int DELTA_BIT = BANK_W + 1;

    typedef struct packed {
        logic              delta;
        logic              wide;
        logic [BANK_W-1:0] bank;
    } gamma_cfg_t;

    typedef logic [NCH-1:0][DW-1:0] chan_vec_t;
    typedef logic [NCH-1:0][IDX_W-1:0] code_vec_t;

    function automatic logic [DW-1:0] rebuild(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] prev,
                                              input logic wide,
                                              input logic use_delta);
        logic [DW-1:0] v;
        v = use_delta ? (cur + prev) : cur;
        if (!wide) v[DW-1:NARROW_W] = '0;
        return v;
    endfunction

endpackage

// File: rtl/gamma_regs.sv
module gamma_regs
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output gamma_cfg_t        cfg,
    output logic [NCH-1:0]    tab_we,
    output logic [IDX_W-1:0]  tab_idx,
    output chan_vec_t         tab_val
);
    logic              aligned, hit_cfg, hit_w0, hit_w1;
    logic [ADDR_W-1:0] off0, off1;
    logic [ENT_W-1:0]  slot;
    logic              unused_bits;

    assign aligned = (wr_addr[1:0] == 2'b00);
    assign hit_cfg = wr_en && (wr_addr == CFG_ADDR);
    assign hit_w0  = wr_en && aligned && (wr_addr >= WIN0_BASE)
                     && (wr_addr < WIN0_BASE + ADDR_W'(WIN_SPAN));
    assign hit_w1  = wr_en && aligned && (wr_addr >= WIN1_BASE)
                     && (wr_addr < WIN1_BASE + ADDR_W'(WIN_SPAN));
    assign off0    = wr_addr - WIN0_BASE;
    assign off1    = wr_addr - WIN1_BASE;
    assign slot    = hit_w1 ? off1[ENT_W+1:2] : off0[ENT_W+1:2];
    assign tab_idx = {cfg.bank, slot};
    assign unused_bits = ^{wr_data[WORD_W-1:3*NARROW_W], off0[ADDR_W-1:ENT_W+2],
                           off0[1:0], off1[ADDR_W-1:ENT_W+2], off1[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (hit_cfg) begin
            cfg.bank  <= wr_data[BANK_W-1:0];
            cfg.wide  <= wr_data[WIDE_BIT];
            cfg.delta <= wr_data[DELTA_BIT];
        end
    end

    always_comb begin
        tab_we  = '0;
        tab_val = '0;
        if (cfg.wide) begin
            tab_val[0] = wr_data[DW-1:0];
            tab_val[1] = wr_data[2*DW-1:DW];
            tab_val[2] = wr_data[DW-1:0];
            tab_we[0]  = hit_w0;
            tab_we[1]  = hit_w0;
            tab_we[2]  = hit_w1;
        end else begin
            tab_val[0] = DW'(wr_data[3*NARROW_W-1:2*NARROW_W]);
            tab_val[1] = DW'(wr_data[2*NARROW_W-1:NARROW_W]);
            tab_val[2] = DW'(wr_data[NARROW_W-1:0]);
            tab_we     = {NCH{hit_w0}};
        end
    end

    assert_reset_cfg_R1: assert property (@(posedge clk) rst |=> cfg == '0);

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (rst)
        hit_cfg |=> (cfg.bank == $past(wr_data[BANK_W-1:0])) &&
                    (cfg.wide == $past(wr_data[WIDE_BIT])) &&
                    (cfg.delta == $past(wr_data[DELTA_BIT])));

    assert_blue_only_wide_R5: assert property (@(posedge clk) disable iff (rst)
        (tab_we[2] && !tab_we[0]) |-> cfg.wide);

    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !hit_cfg |=> $stable(cfg));

endmodule

// File: rtl/gamma_chan_table.sv
module gamma_chan_table
    import gamma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    cur_q,
    output logic [DW-1:0]    prev_q
);
    logic [DW-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    always_ff @(posedge clk) begin
        cur_q  <= mem[ridx];
        prev_q <= mem[{ridx[IDX_W-1:1], 1'b0}];
    end

    assert_store_write_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(widx)] == $past(wdata));

endmodule

// File: rtl/gamma_recon.sv
module gamma_recon
    import gamma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           v1,
    input  logic [NCH-1:0] odd1,
    input  logic           wide1,
    input  logic           delta1,
    input  chan_vec_t      cur,
    input  chan_vec_t      prev,
    output logic           out_valid,
    output chan_vec_t      out_px
);
    chan_vec_t nxt;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign nxt[c] = rebuild(cur[c], prev[c], wide1, delta1 && odd1[c]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_px    <= '0;
        end else begin
            out_valid <= v1;
            if (v1) out_px <= nxt;
        end
    end

    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
        v1 |=> out_valid);

    assert_valid_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !v1 |=> !out_valid);

    assert_narrow_top_R6: assert property (@(posedge clk) disable iff (rst)
        (v1 && !wide1) |=> (out_px[0][DW-1:NARROW_W] == '0) &&
                           (out_px[1][DW-1:NARROW_W] == '0) &&
                           (out_px[2][DW-1:NARROW_W] == '0));

endmodule

// File: rtl/gamma_lut_pipe.sv
module gamma_lut_pipe
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_r,
    input  logic [IDX_W-1:0]  in_g,
    input  logic [IDX_W-1:0]  in_b,
    output logic              out_valid,
    output logic [DW-1:0]     out_r,
    output logic [DW-1:0]     out_g,
    output logic [DW-1:0]     out_b
);
    gamma_cfg_t     cfg;
    logic [NCH-1:0] tab_we;
    logic [IDX_W-1:0] tab_idx;
    chan_vec_t      tab_val;
    code_vec_t      code;
    chan_vec_t      cur, prev, px;
    logic           v1, wide1, delta1;
    logic [NCH-1:0] odd1;

    assign code = {in_b, in_g, in_r};

    gamma_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .tab_we  (tab_we),
        .tab_idx (tab_idx),
        .tab_val (tab_val)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_tab
        gamma_chan_table u_tab (
            .clk    (clk),
            .rst    (rst),
            .we     (tab_we[c]),
            .widx   (tab_idx),
            .wdata  (tab_val[c]),
            .ridx   (code[c]),
            .cur_q  (cur[c]),
            .prev_q (prev[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1     <= 1'b0;
            odd1   <= '0;
            wide1  <= 1'b0;
            delta1 <= 1'b0;
        end else begin
            v1     <= in_valid;
            wide1  <= cfg.wide;
            delta1 <= cfg.delta;
            for (int c = 0; c < NCH; c++) odd1[c] <= code[c][0];
        end
    end

    gamma_recon u_recon (
        .clk       (clk),
        .rst       (rst),
        .v1        (v1),
        .odd1      (odd1),
        .wide1     (wide1),
        .delta1    (delta1),
        .cur       (cur),
        .prev      (prev),
        .out_valid (out_valid),
        .out_px    (px)
    );

    assign out_r = px[0];
    assign out_g = px[1];
    assign out_b = px[2];

    assert_stage1_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> v1);

    assert_mode_snap_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wide1 == $past(cfg.wide)) && (delta1 == $past(cfg.delta)));

endmodule

// File: tb/sim_gamma_lut_pipe.sv
module sim_gamma_lut_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_r = '0, in_g = '0, in_b = '0;
    logic        out_valid;
    logic [11:0] out_r, out_g, out_b;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    int m_tab [3][1024];
    int m_bank = 0;
    bit m_wide = 0, m_delta = 0;

    bit    e0v = 0, e1v = 0;
    int    e0 [3], e1 [3];
    string e0t = "R9", e1t = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    gamma_lut_pipe u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic int lookup(int c, int idx);
        int v, mask;
        mask = m_wide ? 32'hFFF : 32'h3FF;
        v = m_tab[c][idx];
        if (m_delta && (idx % 2 == 1)) v = v + m_tab[c][idx - 1];
        return v & mask;
    endfunction

    function automatic void model_write(int a, int d);
        int slot;
        if (a == 32'h100) begin
            m_bank  = d & 3;
            m_wide  = d[2];
            m_delta = d[3];
        end else if (a % 4 == 0 && a >= 32'h700 && a < 32'hB00) begin
            slot = m_bank * 256 + (a - 32'h700) / 4;
            if (m_wide) begin
                m_tab[0][slot] = d & 32'hFFF;
                m_tab[1][slot] = (d >> 12) & 32'hFFF;
            end else begin
                m_tab[0][slot] = (d >> 20) & 32'h3FF;
                m_tab[1][slot] = (d >> 10) & 32'h3FF;
                m_tab[2][slot] = d & 32'h3FF;
            end
        end else if (a % 4 == 0 && a >= 32'hB00 && a < 32'hF00 && m_wide) begin
            slot = m_bank * 256 + (a - 32'hB00) / 4;
            m_tab[2][slot] = d & 32'hFFF;
        end
    endfunction

    task automatic compare();
        checks++;
        if (!e1v) begin
            if (out_valid !== 1'b0) begin
                fails++;
                $display("FAIL %s: out_valid got %0b expected 0", e1t, out_valid);
            end
        end else if (out_valid !== 1'b1 || out_r !== 12'(e1[0]) ||
                     out_g !== 12'(e1[1]) || out_b !== 12'(e1[2])) begin
            fails++;
            $display("FAIL %s: got v=%0b rgb=%h/%h/%h expected v=1 rgb=%h/%h/%h",
                     e1t, out_valid, out_r, out_g, out_b, e1[0], e1[1], e1[2]);
        end
    endtask

    task automatic step(bit w, int a, int d, bit p, int ir, int ig, int ib, string tag);
        @(negedge clk);
        cyc++;
        compare();
        e1v = e0v; e1 = e0; e1t = e0t;
        e0v = p;
        e0t = p ? tag : "R9";
        if (p) begin
            e0[0] = lookup(0, ir);
            e0[1] = lookup(1, ig);
            e0[2] = lookup(2, ib);
        end
        if (w) void'(model_write(a, d));
        wr_en = w; wr_addr = 12'(a); wr_data = 32'(d);
        in_valid = p; in_r = 10'(ir); in_g = 10'(ig); in_b = 10'(ib);
    endtask

    task automatic wr(int a, int d);
        step(1, a, d, 0, 0, 0, 0, "R9");
    endtask

    task automatic px(int ir, int ig, int ib, string tag);
        step(0, 0, 0, 1, ir, ig, ib, tag);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, "R9");
    endtask

    function automatic int pat(int c, int i);
        return ((i * (37 + c * 16)) + c * 101 + 7) & 32'h3FF;
    endfunction

    function automatic int nword(int r, int g, int b);
        return ((r & 32'h3FF) << 20) | ((g & 32'h3FF) << 10) | (b & 32'h3FF);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > WATCHDOG && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        for (int c = 0; c < 3; c++) for (int i = 0; i < 1024; i++) m_tab[c][i] = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_valid in reset got %0b expected 0", out_valid);
        end
        rst = 1'b0;

        // R1: no bank write yet, so window lands in bank 0, narrow layout
        for (int i = 0; i < 256; i++) wr(32'h700 + 4 * i, nword(pat(0, i), pat(1, i), pat(2, i)));
        // R5: blue window ignored in narrow layout
        for (int i = 0; i < 16; i++) wr(32'hB00 + 4 * i, 32'hFFF);
        for (int b = 1; b < 4; b++) begin
            wr(32'h100, b);
            for (int i = 0; i < 256; i++) begin
                int n = b * 256 + i;
                wr(32'h700 + 4 * i, nword(pat(0, n), pat(1, n), pat(2, n)));
            end
        end
        idle(2);

        px(0, 1, 2, "R1");
        px(3, 5, 7, "R1");
        for (int i = 0; i < 16; i++) px(i, i, i, "R5");
        idle(1);
        for (int i = 0; i < 40; i++) begin
            px((i * 97) % 1024, (i * 211 + 3) % 1024, (i * 389 + 1) % 1024, "R3");
            if (i % 5 == 0) idle(i % 3);
        end
        for (int i = 0; i < 8; i++) px(2 * i + 1, 2 * i + 257, 2 * i + 769, "R8");
        px(1023, 1023, 1023, "R6");

        // R7 narrow deltas with wrap
        wr(32'h100, 32'h8);
        wr(32'h700 + 4 * 4, nword(32'h3F0, 32'h200, 32'h001));
        wr(32'h700 + 4 * 5, nword(32'h020, 32'h200, 32'h3FF));
        for (int i = 0; i < 10; i++) px(i, i + 300, i + 601, "R7");
        px(4, 4, 4, "R7");
        px(5, 5, 5, "R7");

        // R4 wide layout, bank 2, delta off
        wr(32'h100, 32'h6);
        for (int i = 0; i < 8; i++) begin
            wr(32'h700 + 4 * i, ((32'hA00 + i * 16'h111) << 12) | (32'hFF0 - i * 3));
            wr(32'hB00 + 4 * i, 32'hC00 + i * 32'h77);
        end
        wr(32'h700 + 4 * 1, (32'h030 << 12) | 32'h030);
        wr(32'hB00 + 4 * 1, 32'h0FF);
        for (int i = 0; i < 8; i++) px(512 + i, 512 + i, 512 + i, "R4");
        // R2 delta bit on, wide stays, bank 2
        wr(32'h100, 32'hE);
        for (int i = 0; i < 8; i++) px(512 + i, 519 - i, 512 + i, "R7");
        // R6 narrow masking of wide-written entries, bank 2
        wr(32'h100, 32'h2);
        for (int i = 0; i < 4; i++) px(512 + i, 512 + i, 512 + i, "R6");

        // R10 write and pixel on the same edge
        step(1, 32'h700 + 4 * 9, nword(32'h111, 32'h222, 32'h333), 1, 521, 521, 521, "R10");
        px(521, 521, 521, "R10");
        step(1, 32'h100, 32'hA, 1, 515, 515, 515, "R10");
        px(515, 515, 515, "R10");
        wr(32'h100, 32'h2);

        // R11 stray addresses
        wr(32'h104, 32'hF);
        wr(32'h702, nword(32'h0AA, 32'h0BB, 32'h0CC));
        wr(32'h6FC, nword(32'h0AA, 32'h0BB, 32'h0CC));
        wr(32'hF00, nword(32'h0AA, 32'h0BB, 32'h0CC));
        wr(32'hF04, nword(32'h0AA, 32'h0BB, 32'h0CC));
        px(512, 512, 512, "R11");
        px(513, 767, 1023, "R11");
        px(511, 0, 768, "R11");
        // R2 bank field reaches bank 3 again
        wr(32'h100, 32'h3);
        wr(32'h700 + 4 * 255, nword(32'h155, 32'h2AA, 32'h0F0));
        px(1023, 1023, 1023, "R2");
        idle(4);
        finish_run();
    end
endmodule